// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Decoder

This block turns the three Hall sensor levels of a brushless motor into enables for the six gates of a three-phase half-bridge. The sensors are spaced 120 electrical degrees apart. A rotation-direction input picks one of two phase tables. Each valid Hall code selects one phase whose high side conducts and one phase whose low side conducts. Codes 000 and 111 are treated as a sensor fault, and the bridge coasts.

A speed PWM input and an off-request from the current chopper both open an off interval. During an off interval the decay-mode input chooses the recirculation path. In slow decay both low sides of the active pair conduct. In fast decay only the low side of the phase that was driving high conducts, as low-side-only synchronous rectification.

Every gate change passes through a per-leg dead-time guard. The guard turns a gate off at once, but turns a gate on only after both gates of that leg have been low for a programmable number of clock cycles. An inhibit input from the brake/coast controller overrides the decoded pattern. The block also gives a one-cycle strobe on each change of valid Hall code and a flag for an invalid code.

Top module: `hall_commutator`

## Requirements
- R1: The gates follow this table when `dir_i`=1 and no off interval is active. Bit 0, bit 1 and bit 2 of `gh_o`/`gl_o` are phases A, B and C. The table gives the Hall code as {h2,h1,h0}, then the high-side phase, then the low-side phase:
  - 101: high A, low C
  - 100: high B, low C
  - 110: high B, low A
  - 010: high C, low A
  - 011: high C, low B
  - 001: high A, low B
- R2: With `dir_i`=0 the table of R1 applies with the high-side and low-side phases exchanged. For example, 101 gives high C and low A.
- R3: Hall codes 000 and 111 turn all six gates off unless inhibit is active. They also set `hall_bad_o` to 1 one cycle after the code is sampled. Valid codes set it to 0.
- R4: In an off interval with `mode_i`=1 (slow decay), all high sides are off. Both low sides of the active pair are on.
- R5: In an off interval with `mode_i`=0 (fast decay), all high sides are off. Only the low side of the phase selected for the high side is on.
- R6: An off interval exists when `pwm_i`=0 or `chop_off_i`=1. Both sources have the same effect.
- R7: A gate turns off at the clock edge after its request drops. A gate turns on only after both gates of its leg have been low for at least `dead_cycles_i`+1 cycles. Without a dead-time wait, a new pattern shows on the outputs one cycle after it is sampled.
- R8: The two gates of one leg are never on together. A request for both gates of a leg turns both off.
- R9: `comm_stb_o` pulses for one cycle whenever the sampled valid Hall code differs from the last valid code. The first valid code after reset counts as a change. An invalid code gives no pulse, and neither does a return to the same valid code after an invalid one.
- R10: While `inhibit_i`=1, the requests are taken from `inh_gl_i`/`inh_gh_i` whatever the Hall code, PWM and mode inputs are. These requests still pass through the dead-time guard.
- R11: After reset, all gates are off and `comm_stb_o` and `hall_bad_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_i | input | 3 | Hall levels {h2,h1,h0}, already filtered |
| dir_i | input | 1 | Rotation direction select |
| pwm_i | input | 1 | Speed PWM; 0 opens an off interval |
| mode_i | input | 1 | Decay mode: 1 slow, 0 fast |
| chop_off_i | input | 1 | Off-time request from the current chopper |
| inhibit_i | input | 1 | Override by brake/coast controller |
| inh_gl_i | input | 3 | Low-side pattern used during inhibit |
| inh_gh_i | input | 3 | High-side pattern used during inhibit |
| dead_cycles_i | input | DT_W | Dead time in clock cycles |
| gl_o | output | 3 | Low-side gate enables, bit 0 = phase A |
| gh_o | output | 3 | High-side gate enables, bit 0 = phase A |
| comm_stb_o | output | 1 | One-cycle commutation strobe |
| hall_bad_o | output | 1 | Invalid Hall code flag |

## Verification
The assertions assume that `hall_i` is already synchronous and filtered. They also assume that `dead_cycles_i` changes only while the legs are idle or holding a steady pattern, so a gap measured against the new value is still long enough. The bench changes every input only on the falling clock edge. It alters the dead time only between sweeps, after the patterns have settled. The bench sweeps all 128 combinations of Hall code, direction, PWM, mode and chop request at two dead times. It also watches every leg for overlap and for short gaps on every cycle.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
   typedef enum logic [1:0] {
      PH_A    = 2'd0,
      PH_B    = 2'd1,
      PH_C    = 2'd2,
      PH_NONE = 2'd3
   } phase_e;

   typedef struct packed {
      logic [2:0] gl;
      logic [2:0] gh;
   } gate_pat_t;

   function automatic logic hall_ok(input logic [2:0] h);
      return (h != 3'b000) && (h != 3'b111);
   endfunction

   function automatic logic [2:0] phase_mask(input phase_e p);
      return (p == PH_NONE) ? 3'b000 : 3'(3'b001 << p);
   endfunction
endpackage

// File: rtl/hcd_decode.sv
module hcd_decode
   import hcd_pkg::*;
(
   input  logic [2:0] hall_i,
   input  logic       dir_i,
   input  logic       pwm_i,
   input  logic       mode_i,
   input  logic       chop_off_i,
   input  logic       inhibit_i,
   input  logic [2:0] inh_gl_i,
   input  logic [2:0] inh_gh_i,
   output gate_pat_t  req_o
);
   phase_e fwd_hi, fwd_lo, hi_ph, lo_ph;
   logic [2:0] hi_m, lo_m;
   logic off_iv;

   // forward table; reverse direction swaps the two sides
   always_comb begin
      fwd_hi = PH_NONE;
      fwd_lo = PH_NONE;
      case (hall_i)
         3'b101:  begin fwd_hi = PH_A; fwd_lo = PH_C; end
         3'b100:  begin fwd_hi = PH_B; fwd_lo = PH_C; end
         3'b110:  begin fwd_hi = PH_B; fwd_lo = PH_A; end
         3'b010:  begin fwd_hi = PH_C; fwd_lo = PH_A; end
         3'b011:  begin fwd_hi = PH_C; fwd_lo = PH_B; end
         3'b001:  begin fwd_hi = PH_A; fwd_lo = PH_B; end
         default: ;
      endcase
      hi_ph = dir_i ? fwd_hi : fwd_lo;
      lo_ph = dir_i ? fwd_lo : fwd_hi;
   end

   assign hi_m   = phase_mask(hi_ph);
   assign lo_m   = phase_mask(lo_ph);
   assign off_iv = !pwm_i || chop_off_i;

   always_comb begin
      if (inhibit_i) begin
         req_o.gl = inh_gl_i;
         req_o.gh = inh_gh_i;
      end else if (!off_iv) begin
         req_o.gl = lo_m;
         req_o.gh = hi_m;
      end else if (mode_i) begin
         req_o.gl = hi_m | lo_m;
         req_o.gh = 3'b000;
      end else begin
         req_o.gl = hi_m;
         req_o.gh = 3'b000;
      end
   end

   // R3
   always_comb begin
      if (!inhibit_i && !hall_ok(hall_i))
         bad_code_coast_chk: assert (req_o == '0);
   end
endmodule

// File: rtl/hcd_leg_guard.sv
module hcd_leg_guard #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_l_i,
   input  logic            req_h_i,
   input  logic [DT_W-1:0] dead_i,
   output logic            out_l_o,
   output logic            out_h_o
);
   localparam logic [DT_W-1:0] IDLE_MAX = {DT_W{1'b1}};

   logic [DT_W-1:0] idle_q;
   logic idle_now, open_win, clash;

   assign idle_now = !out_l_o && !out_h_o;
   assign open_win = idle_now && (idle_q >= dead_i);
   assign clash    = req_l_i && req_h_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_l_o <= 1'b0;
         out_h_o <= 1'b0;
         idle_q  <= IDLE_MAX;
      end else begin
         out_l_o <= req_l_i && !clash && (out_l_o || open_win);
         out_h_o <= req_h_i && !clash && (out_h_o || open_win);
         if (!idle_now)
            idle_q <= '0;
         else if (idle_q != IDLE_MAX)
            idle_q <= idle_q + 1'b1;
      end
   end

   // R8
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_l_o && out_h_o));
   // R7
   low_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_l_o) |-> $past(!out_h_o));
   // R7
   high_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_h_o) |-> $past(!out_l_o));
   // R7
   fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_l_i && !req_h_i) |=> (!out_l_o && !out_h_o));
endmodule

// File: rtl/hcd_event.sv
module hcd_event
   import hcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_i,
   output logic       comm_stb_o,
   output logic       hall_bad_o
);
   logic [2:0] last_q;
   logic code_ok;

   assign code_ok = hall_ok(hall_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q     <= 3'b000;
         comm_stb_o <= 1'b0;
         hall_bad_o <= 1'b0;
      end else begin
         hall_bad_o <= !code_ok;
         comm_stb_o <= code_ok && (hall_i != last_q);
         if (code_ok) last_q <= hall_i;
      end
   end

   // R9
   stb_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      comm_stb_o |-> !hall_bad_o);
   // R9
   stb_same_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_ok && $stable(hall_i) && !hall_bad_o) |=> !comm_stb_o);
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
   import hcd_pkg::*;
#(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      hall_i,
   input  logic            dir_i,
   input  logic            pwm_i,
   input  logic            mode_i,
   input  logic            chop_off_i,
   input  logic            inhibit_i,
   input  logic [2:0]      inh_gl_i,
   input  logic [2:0]      inh_gh_i,
   input  logic [DT_W-1:0] dead_cycles_i,
   output logic [2:0]      gl_o,
   output logic [2:0]      gh_o,
   output logic            comm_stb_o,
   output logic            hall_bad_o
);
   localparam int N_LEG = 3;

   if (DT_W < 1 || DT_W > 16) begin : g_bad_dt_w
      $error("hall_commutator: DT_W must lie in 1..16");
   end

   gate_pat_t req;

   hcd_decode u_dec (
      .hall_i     (hall_i),
      .dir_i      (dir_i),
      .pwm_i      (pwm_i),
      .mode_i     (mode_i),
      .chop_off_i (chop_off_i),
      .inhibit_i  (inhibit_i),
      .inh_gl_i   (inh_gl_i),
      .inh_gh_i   (inh_gh_i),
      .req_o      (req)
   );

   for (genvar g = 0; g < N_LEG; g++) begin : g_leg
      hcd_leg_guard #(.DT_W(DT_W)) u_leg (
         .clk     (clk),
         .rst_n   (rst_n),
         .req_l_i (req.gl[g]),
         .req_h_i (req.gh[g]),
         .dead_i  (dead_cycles_i),
         .out_l_o (gl_o[g]),
         .out_h_o (gh_o[g])
      );
   end

   hcd_event u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .hall_i     (hall_i),
      .comm_stb_o (comm_stb_o),
      .hall_bad_o (hall_bad_o)
   );

   // R3
   coast_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hall_ok(hall_i) && !inhibit_i) |=> (gl_o == 3'b000 && gh_o == 3'b000));
   // R1
   one_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inhibit_i |=> $onehot0(gh_o));
   // R4
   off_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inhibit_i && (!pwm_i || chop_off_i)) |=> (gh_o == 3'b000));
endmodule

// File: tb/sim_hall_commutator.sv
module sim_hall_commutator;
   localparam int CLK_PERIOD = 10;
   localparam int DT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] hall = 3'b000;
   logic dir = 1'b1, pwm = 1'b1, mode = 1'b1, chop = 1'b0, inh = 1'b0;
   logic [2:0] inh_gl = 3'b000, inh_gh = 3'b000;
   logic [DT_W-1:0] dead = 8'd3;
   logic [2:0] gl, gh;
   logic stb, bad;

   int n_chk = 0, n_fail = 0;
   bit mon_en = 1'b0;
   int run [3];
   logic [2:0] p_gl = 3'b000, p_gh = 3'b000;

   always #(CLK_PERIOD/2) clk = ~clk;

   hall_commutator #(.DT_W(DT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_i(dir), .pwm_i(pwm),
      .mode_i(mode), .chop_off_i(chop), .inhibit_i(inh), .inh_gl_i(inh_gl),
      .inh_gh_i(inh_gh), .dead_cycles_i(dead), .gl_o(gl), .gh_o(gh),
      .comm_stb_o(stb), .hall_bad_o(bad)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   function automatic int seq_code(input int i);
      case (i)
         0: return 5;  1: return 4;  2: return 6;
         3: return 2;  4: return 3;  default: return 1;
      endcase
   endfunction

   // expected {gl,gh} from the requirement tables
   function automatic logic [5:0] exp_pat(input int h, input bit d, input bit p,
                                          input bit m, input bit c);
      int pos = -1, hi, lo, t;
      logic [2:0] hm, lm;
      for (int i = 0; i < 6; i++) if (seq_code(i) == h) pos = i;
      if (pos < 0) return 6'b0;
      hi = ((pos + 1) / 2) % 3;
      lo = (pos / 2 + 2) % 3;
      if (!d) begin t = hi; hi = lo; lo = t; end
      hm = 3'(1 << hi);
      lm = 3'(1 << lo);
      if (p && !c) return {lm, hm};
      if (m) return {hm | lm, 3'b000};
      return {hm, 3'b000};
   endfunction

   function automatic string tag_of(input int h, input bit d, input bit p,
                                    input bit m, input bit c);
      if (h == 0 || h == 7) return "R3";
      if (p && c) return "R6";
      if (!p || c) return m ? "R4" : "R5";
      return d ? "R1" : "R2";
   endfunction

   // per-cycle leg monitor: R7 gap and R8 overlap
   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         for (int g = 0; g < 3; g++) begin
            check(!(gl[g] && gh[g]), "R8", "leg overlap", {gl[g], gh[g]}, 0);
            if ((gl[g] && !p_gl[g]) || (gh[g] && !p_gh[g]))
               check(run[g] >= int'(dead) + 1, "R7", "gap before turn-on",
                     run[g], int'(dead) + 1);
            if (!gl[g] && !gh[g]) run[g]++;
            else run[g] = 0;
         end
         p_gl = gl;
         p_gh = gh;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      int cnt;
      for (int g = 0; g < 3; g++) run[g] = 1000;
      repeat (3) @(negedge clk);
      // R11
      check(gl == 0 && gh == 0, "R11", "gates in reset", {gl, gh}, 0);
      check(stb == 0 && bad == 0, "R11", "flags in reset", {stb, bad}, 0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      @(negedge clk);
      check(bad == 1, "R3", "bad flag for 000", bad, 1);
      check(stb == 0, "R9", "no strobe on 000", stb, 0);

      // R9 strobe sequence
      hall = 3'b101;
      @(negedge clk);
      check(stb == 1, "R9", "first valid strobe", stb, 1);
      check(bad == 0, "R3", "bad flag cleared", bad, 0);
      @(negedge clk);
      check(stb == 0, "R9", "strobe one cycle", stb, 0);
      hall = 3'b111;
      @(negedge clk);
      check(stb == 0 && bad == 1, "R9", "invalid no strobe", {stb, bad}, 1);
      hall = 3'b101;
      @(negedge clk);
      check(stb == 0, "R9", "return no strobe", stb, 0);
      hall = 3'b100;
      @(negedge clk);
      check(stb == 1, "R9", "change strobe", stb, 1);

      // R7 exact gap: slow-decay off after drive on leg A
      dead = 8'd5; hall = 3'b101; dir = 1; pwm = 1; mode = 1; chop = 0;
      repeat (12) @(negedge clk);
      check({gl, gh} == 6'b100_001, "R1", "101 forward", {gl, gh}, 6'b100_001);
      pwm = 1'b0;
      @(negedge clk);
      check(gh[0] == 0, "R7", "high side off next cycle", gh[0], 0);
      cnt = 1;
      while (!gl[0] && cnt < 50) begin @(negedge clk); cnt++; end
      check(cnt == 7, "R7", "both-low cycles before low on", cnt - 1, 6);

      // sweeps
      foreach (dead_set[k]) begin
         dead = dead_set[k];
         for (int i = 0; i < 128; i++) begin
            logic [5:0] e;
            hall = i[2:0]; dir = i[3]; pwm = i[4]; mode = i[5]; chop = i[6];
            e = exp_pat(i[2:0], i[3], i[4], i[5], i[6]);
            repeat (int'(dead) + 4) @(negedge clk);
            check({gl, gh} == e, tag_of(i[2:0], i[3], i[4], i[5], i[6]),
                  "gate pattern", {gl, gh}, e);
            check(bad == (i[2:0] == 0 || i[2:0] == 7), "R3", "bad flag",
                  bad, (i[2:0] == 0 || i[2:0] == 7));
         end
      end

      // R10 inhibit override
      dead = 8'd2; hall = 3'b101; pwm = 1; inh = 1;
      inh_gl = 3'b111; inh_gh = 3'b000;
      repeat (8) @(negedge clk);
      check({gl, gh} == 6'b111_000, "R10", "brake pattern", {gl, gh}, 6'b111_000);
      hall = 3'b000;
      repeat (3) @(negedge clk);
      check({gl, gh} == 6'b111_000 && bad, "R10", "inhibit over bad code",
            {bad, gl, gh}, 7'b1_111_000);
      inh_gl = 3'b000; inh_gh = 3'b010;
      repeat (8) @(negedge clk);
      check({gl, gh} == 6'b000_010, "R10", "inhibit high pattern", {gl, gh}, 6'b000_010);
      inh_gl = 3'b011; inh_gh = 3'b101;
      repeat (8) @(negedge clk);
      check({gl, gh} == 6'b010_100, "R8", "conflicting leg request",
            {gl, gh}, 6'b010_100);
      inh_gl = 3'b000; inh_gh = 3'b000;
      repeat (3) @(negedge clk);
      check({gl, gh} == 0, "R10", "coast pattern", {gl, gh}, 0);
      finish_up();
   end

   logic [DT_W-1:0] dead_set [2] = '{8'd0, 8'd7};
endmodule